// File: doc/BRIEF.md
# Bit-Serial Montgomery Multiplier with Shift Merging

This block computes the Montgomery product X·Y·2^-n mod N for an odd modulus N of parameter width n. The multiplier operand X is consumed one bit per iteration, least significant bit first. The running accumulator is kept as two vectors, a sum and a carry. Because of this, an iteration never waits on a full-width carry chain. Each iteration looks at the parity of the accumulator plus the conditional Y term. From that parity and the current X bit it adds zero, Y, N or a precomputed Y+N, and then halves the result.

An iteration can be pure shifting: the next X bit is zero and the bit that will become the accumulator's LSB is zero in both vectors. In that case the block merges it with the current one and shifts by two bits. It never merges across the last X bit, so exactly n bits of X are used. Once all bits are used, the block adds the two vectors once, subtracts N once if the sum is not below N, and then returns the result.

The interface has plain control pins. A one-cycle `start` in idle captures the operands. `done` pulses for one cycle when `result` becomes valid, and `result` then holds until the next operation completes. There is no data handshake: a `start` raised while an operation is running is ignored.

Top module: `mont_skip_mul`

## Requirements
- R1: For odd N, Y < N and any n-bit X, `result` equals X·Y·2^-n mod N and is strictly below N.
- R2: `done` is high for exactly one cycle per accepted operation.
- R3: `result` keeps its value in every cycle except the cycle in which `done` is high.
- R4: A `start` pulse raised while an operation is in progress is ignored, and the running operation completes with its original operands.
- R5: After reset, `done` is low and `result` is zero.
- R6: If every bit of X is one, no iteration is merged, and `done` rises n+1 clock edges after the edge that accepts `start`.
- R7: If Y is zero and X is zero, every iteration merges two bits, and `done` rises n/2+1 edges after the accepting edge (n even).
- R8: A one in bit i+1 of X blocks merging at bit i. For X with only bit n-1 set and Y = 0, `done` rises n/2+2 edges after the accepting edge.
- R9: Merging never starts at bit n-1. For X = 2 and Y = 0, `done` rises n/2+2 edges after the accepting edge.
- R10: For any operands, the number of edges from acceptance to `done` lies between ceil(n/2)+1 and n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| x_in | input | NW | Multiplier operand X, scanned bit by bit |
| y_in | input | NW | Multiplicand Y, must be below N |
| n_in | input | NW | Odd modulus N |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | NW | Montgomery product, held between operations |

## Verification
Two things can coincide in one iteration: the conditional addition of Y and/or N, and the merged two-bit shift. They coincide when an iteration that adds a term leaves zeros in the next low bit of both carry-save vectors while the next X bit is zero. Random odd moduli and random operands produce many such iterations, and each product is judged against a wide-integer model that uses modular halving. A wrong drop of a set low bit, or a merge over a one in X, therefore shows up as a wrong product. Edge-exact latency checks with crafted X patterns pin down when merging is forced, blocked and suppressed.

// File: rtl/mont_skip_pkg.sv
package mont_skip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mm_state_e;
endpackage

// File: rtl/mont_csa_step.sv
module mont_csa_step #(
  parameter int NW = 32,
  localparam int W = NW + 2
) (
  input  logic [W-1:0]  ss,
  input  logic [W-1:0]  sc,
  input  logic          xi,
  input  logic          xnext,
  input  logic          next_ok,
  input  logic [NW-1:0] yv,
  input  logic [NW-1:0] nv,
  input  logic [W-1:0]  ynv,
  output logic [W-1:0]  ss_nx,
  output logic [W-1:0]  sc_nx,
  output logic          skip
);
  logic          odd;
  logic [W-1:0]  term;
  logic [W-1:0]  s1;
  logic [W-1:0]  maj;

  always_comb begin
    odd = ss[0] ^ sc[0] ^ (xi & yv[0]);
    unique case ({odd, xi})
      2'b00:   term = '0;
      2'b01:   term = {2'b00, yv};
      2'b10:   term = {2'b00, nv};
      default: term = ynv;
    endcase
    s1  = ss ^ sc ^ term;
    maj = (ss & sc) | (ss & term) | (sc & term);
    skip = next_ok & ~xnext & ~s1[1] & ~maj[0];
    if (skip) begin
      ss_nx = s1 >> 2;
      sc_nx = maj >> 1;
    end else begin
      ss_nx = s1 >> 1;
      sc_nx = maj;
    end
  end

  // R1: the added term makes the sum even, so the dropped sum bit is zero
  always_comb begin
    if (nv[0]) a_r1_even_sum: assert (s1[0] == 1'b0);
  end

  // R8: never merge when the following X bit is one
  always_comb begin
    a_r8_no_merge_over_one: assert (!(skip && xnext));
  end
endmodule

// File: rtl/mont_final_reduce.sv
module mont_final_reduce #(
  parameter int NW = 32,
  localparam int W = NW + 2
) (
  input  logic [W-1:0]  ss,
  input  logic [W-1:0]  sc,
  input  logic [NW-1:0] nv,
  output logic [NW-1:0] red
);
  logic [W:0] full;
  logic [W:0] diff;

  always_comb begin
    full = {1'b0, ss} + {1'b0, sc};
    diff = full - {{(W+1-NW){1'b0}}, nv};
    if (full >= {{(W+1-NW){1'b0}}, nv}) red = diff[NW-1:0];
    else red = full[NW-1:0];
  end
endmodule

// File: rtl/mont_skip_mul.sv
module mont_skip_mul #(
  parameter int NW = 32,
  localparam int W  = NW + 2,
  localparam int IW = $clog2(NW + 2) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] x_in,
  input  logic [NW-1:0] y_in,
  input  logic [NW-1:0] n_in,
  output logic          done,
  output logic [NW-1:0] result
);
  import mont_skip_pkg::*;

  mm_state_e      state_q;
  logic [W-1:0]   ss_q, sc_q, yn_q;
  logic [NW-1:0]  x_q, y_q, n_q, res_q;
  logic [IW-1:0]  idx_q;
  logic           done_q;

  logic [W-1:0]   ss_nx, sc_nx;
  logic           skip;
  logic           next_ok;
  logic [IW-1:0]  idx_nx;
  logic [NW-1:0]  red;

  assign next_ok = (idx_q + IW'(1)) < IW'(NW);
  assign idx_nx  = idx_q + (skip ? IW'(2) : IW'(1));

  mont_csa_step #(.NW(NW)) u_step (
    .ss(ss_q), .sc(sc_q), .xi(x_q[0]), .xnext(x_q[1]), .next_ok(next_ok),
    .yv(y_q), .nv(n_q), .ynv(yn_q),
    .ss_nx(ss_nx), .sc_nx(sc_nx), .skip(skip)
  );

  mont_final_reduce #(.NW(NW)) u_fin (
    .ss(ss_q), .sc(sc_q), .nv(n_q), .red(red)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ss_q    <= '0;
      sc_q    <= '0;
      yn_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      n_q     <= '0;
      res_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ss_q    <= '0;
            sc_q    <= '0;
            x_q     <= x_in;
            y_q     <= y_in;
            n_q     <= n_in;
            yn_q    <= {2'b00, y_in} + {2'b00, n_in};
            idx_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          ss_q  <= ss_nx;
          sc_q  <= sc_nx;
          x_q   <= skip ? (x_q >> 2) : (x_q >> 1);
          idx_q <= idx_nx;
          if (idx_nx >= IW'(NW)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          res_q   <= red;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign result = res_q;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FIN) |=> $stable(res_q));

  a_r1_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q < n_q));

  a_r9_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (idx_q < IW'(NW)));

  a_r4_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> $stable(n_q) && $stable(y_q));
endmodule

// File: tb/mont_skip_mul_tb_top.sv
module mont_skip_mul_tb_top;
  localparam int NW = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] x_in = '0, y_in = '0, n_in = '0;
  logic          done;
  logic [NW-1:0] result;

  int checks = 0;
  int fails = 0;
  int skipped_total = 0;
  int cyc = 0;

  mont_skip_mul #(.NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .n_in(n_in),
    .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NW-1:0] ref_mont(logic [NW-1:0] x, logic [NW-1:0] y, logic [NW-1:0] n);
    logic [2*NW+1:0] r;
    r = ({{(NW+2){1'b0}}, x} * {{(NW+2){1'b0}}, y}) % {{(NW+2){1'b0}}, n};
    for (int k = 0; k < NW; k++) begin
      if (r[0]) r = r + {{(NW+2){1'b0}}, n};
      r = r >> 1;
    end
    return r[NW-1:0];
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor: R2 pulse width and R3 hold
  logic          prev_done = 1'b0;
  logic [NW-1:0] prev_res = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_done && done) begin
        fails++;
        $display("FAIL R2 actual=done_twice expected=single_pulse");
      end
      if (!done && result !== prev_res) begin
        fails++;
        $display("FAIL R3 actual=%0h expected=%0h", result, prev_res);
      end
    end
    prev_done = done;
    prev_res  = result;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_op(logic [NW-1:0] x, logic [NW-1:0] y, logic [NW-1:0] n,
                        output int lat, output logic [NW-1:0] res);
    @(negedge clk);
    x_in = x; y_in = y; n_in = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    int lat;
    logic [NW-1:0] res, xv, yv, nv, expv;
    repeat (3) @(negedge clk);
    // R5 reset state
    check(done == 1'b0, "R5", done, 0);
    check(result == '0, "R5", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: all-ones X, no merging
    nv = 32'hF123_4567; yv = 32'h1234_5678;
    run_op('1, yv, nv, lat, res);
    check(lat == NW + 1, "R6", lat, NW + 1);
    check(res == ref_mont('1, yv, nv), "R1", res, ref_mont('1, yv, nv));

    // R7: zero operands, every step merges
    run_op('0, '0, nv, lat, res);
    check(lat == NW/2 + 1, "R7", lat, NW/2 + 1);
    check(res == '0, "R1", res, 0);

    // R8: top bit only blocks the last merge
    run_op(32'h8000_0000, '0, nv, lat, res);
    check(lat == NW/2 + 2, "R8", lat, NW/2 + 2);

    // R9: merge suppressed from bit n-1
    run_op(32'h0000_0002, '0, nv, lat, res);
    check(lat == NW/2 + 2, "R9", lat, NW/2 + 2);

    // R1 corner: Y = N-1, X = all ones, smallest odd modulus
    run_op('1, nv - 1, nv, lat, res);
    check(res == ref_mont('1, nv - 1, nv), "R1", res, ref_mont('1, nv - 1, nv));
    run_op(32'hDEAD_BEEF, 32'h0, 32'h3, lat, res);
    check(res == 0, "R1", res, 0);
    run_op(32'hDEAD_BEEF, 32'h2, 32'h3, lat, res);
    check(res == ref_mont(32'hDEAD_BEEF, 2, 3), "R1", res, ref_mont(32'hDEAD_BEEF, 2, 3));

    // R4: start while busy is ignored
    @(negedge clk);
    x_in = 32'h1357_9BDF; y_in = 32'h0246_8ACE; n_in = nv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    x_in = 32'hFFFF_0000; y_in = 32'h1; n_in = 32'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    expv = ref_mont(32'h1357_9BDF, 32'h0246_8ACE, nv);
    check(result == expv, "R4", result, expv);
    repeat (4) @(negedge clk);
    check(result == expv, "R3", result, expv);

    // R1, R10: random operands
    for (int t = 0; t < 300; t++) begin
      nv = $urandom | 32'h1;
      if (t % 2 == 0) nv[NW-1] = 1'b1;
      yv = $urandom % nv;
      xv = $urandom;
      if (t % 5 == 0) xv = xv & 32'h1111_1111;
      run_op(xv, yv, nv, lat, res);
      expv = ref_mont(xv, yv, nv);
      check(res == expv, "R1", res, expv);
      check(lat >= NW/2 + 1 && lat <= NW + 1, "R10", lat, NW + 1);
      skipped_total += NW - (lat - 1);
    end
    $display("merged iterations over random runs: %0d", skipped_total);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule